// File: doc/BRIEF.md
# Reserved Control Word Filter

This block sits on the receive side of a 16-bit packet interface that marks each word as either a control word or a payload word. It looks at the top four bits of every valid control word. When those bits carry one of four codes set aside as reserved or as extension markers, the block drops that control word and raises a one-cycle status pulse. It then blocks every payload word that follows, so nothing is written downstream until a usable control word arrives.

Any other control word is forwarded unchanged. It also sets the forwarding gate for the payload behind it. Bit 15 of a control word flags that payload follows. When bit 15 is set, the payload words after that control word are forwarded. When it is clear, they are blocked. All outputs are registered, so every result appears one clock after its input word is presented.

Top module: `rsv_cw_filter`

## Requirements
- R1: A valid control word whose bits [15:12] equal 4'h5 or 4'h3 is not forwarded (no write on the output for it).
- R2: A valid control word whose bits [15:12] equal 4'h1 or 4'h7 is treated the same way as R1: it is not forwarded.
- R3: `rsv_seen` is high in the cycle after each reserved control word (the codes in R1 and R2) and low after every other input cycle.
- R4: Payload words (`in_ctl`=0) presented after a reserved control word produce no write until the next non-reserved control word.
- R5: A non-reserved valid control word with bit 15 set opens forwarding for the payload words after it. A non-reserved valid control word with bit 15 clear closes forwarding.
- R6: After synchronous reset, `out_we` and `rsv_seen` are low and forwarding is closed. Payload written before any control word is dropped.
- R7: A forwarded word appears on `out_word` and `out_ctl` unchanged, with `out_we` high, exactly one clock after it is presented.
- R8: A cycle with `in_valid` low produces no write and no status pulse, and it leaves the forwarding state unchanged.
- R9: Reserved control words on consecutive cycles each produce their own high cycle of `rsv_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_ctl | input | 1 | High when the input word is a control word |
| in_word | input | 16 | Input word |
| out_we | output | 1 | Write enable toward the downstream buffer |
| out_ctl | output | 1 | Control flag of the forwarded word |
| out_word | output | 16 | Forwarded word |
| rsv_seen | output | 1 | One-cycle pulse per reserved control word |

## Verification
The only internal state is the forwarding gate. If the gate is wrong, the payload words after a control word show it one clock later: they are either written when they should be dropped or missing when they should be written. The bench sweeps all sixteen top-nibble values, each followed by payload bursts and idle cycles. Any decode error therefore shows up at the first control word with that nibble, as a wrong `rsv_seen`, and at the first payload word after it, as a wrong `out_we`.

// File: rtl/rsvf_pkg.sv
package rsvf_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    CW_PLAIN    = 2'd0,
    CW_RESERVED = 2'd1,
    CW_EXTEND   = 2'd2
  } cw_kind_t;

  localparam logic [CODE_W-1:0] CODE_RSV_A = 4'h5;
  localparam logic [CODE_W-1:0] CODE_RSV_B = 4'h3;
  localparam logic [CODE_W-1:0] CODE_EXT_OPEN  = 4'h1;
  localparam logic [CODE_W-1:0] CODE_EXT_CLOSE = 4'h7;

  function automatic cw_kind_t classify(input logic [CODE_W-1:0] nib);
    case (nib)
      CODE_RSV_A, CODE_RSV_B:         classify = CW_RESERVED;
      CODE_EXT_OPEN, CODE_EXT_CLOSE:  classify = CW_EXTEND;
      default:                        classify = CW_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/rsvf_decode.sv
module rsvf_decode
  import rsvf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              in_valid,
  input  logic              in_ctl,
  input  logic [WORD_W-1:0] in_word,
  output logic              ctl_reserved,
  output logic              ctl_usable,
  output logic              ctl_opens,
  output logic              data_word
);
  localparam int NIB_MSB = WORD_W - 1;
  localparam int PAY_BIT = WORD_W - 1;

  cw_kind_t kind;

  always_comb begin
    kind         = classify(in_word[NIB_MSB -: CODE_W]);
    ctl_reserved = in_valid && in_ctl && (kind != CW_PLAIN);
    ctl_usable   = in_valid && in_ctl && (kind == CW_PLAIN);
    ctl_opens    = ctl_usable && in_word[PAY_BIT];
    data_word    = in_valid && !in_ctl;
  end
endmodule

// File: rtl/rsvf_gate.sv
module rsvf_gate (
  input  logic clk,
  input  logic rst,
  input  logic ctl_reserved,
  input  logic ctl_usable,
  input  logic ctl_opens,
  output logic gate_open
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_open <= 1'b0;
    end else if (ctl_reserved) begin
      gate_open <= 1'b0;
    end else if (ctl_usable) begin
      gate_open <= ctl_opens;
    end
  end
endmodule

// File: rtl/rsvf_outreg.sv
module rsvf_outreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              ctl,
  input  logic [WORD_W-1:0] word,
  input  logic              flag,
  output logic              out_we,
  output logic              out_ctl,
  output logic [WORD_W-1:0] out_word,
  output logic              out_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_we   <= 1'b0;
      out_ctl  <= 1'b0;
      out_word <= '0;
      out_flag <= 1'b0;
    end else begin
      out_we   <= wr;
      out_flag <= flag;
      if (wr) begin
        out_ctl  <= ctl;
        out_word <= word;
      end
    end
  end
endmodule

// File: rtl/rsv_cw_filter.sv
module rsv_cw_filter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_ctl,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_we,
  output logic              out_ctl,
  output logic [WORD_W-1:0] out_word,
  output logic              rsv_seen
);
  logic ctl_reserved, ctl_usable, ctl_opens, data_word;
  logic gate_open;
  logic wr;

  rsvf_decode #(.WORD_W(WORD_W)) u_dec (
    .in_valid     (in_valid),
    .in_ctl       (in_ctl),
    .in_word      (in_word),
    .ctl_reserved (ctl_reserved),
    .ctl_usable   (ctl_usable),
    .ctl_opens    (ctl_opens),
    .data_word    (data_word)
  );

  rsvf_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .ctl_reserved (ctl_reserved),
    .ctl_usable   (ctl_usable),
    .ctl_opens    (ctl_opens),
    .gate_open    (gate_open)
  );

  assign wr = ctl_usable || (data_word && gate_open);

  rsvf_outreg #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr),
    .ctl      (in_ctl),
    .word     (in_word),
    .flag     (ctl_reserved),
    .out_we   (out_we),
    .out_ctl  (out_ctl),
    .out_word (out_word),
    .out_flag (rsv_seen)
  );
endmodule

// File: rtl/rsv_cw_filter_chk.sv
module rsv_cw_filter_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ctl,
  input logic [WORD_W-1:0] in_word,
  input logic              out_we,
  input logic              out_ctl,
  input logic [WORD_W-1:0] out_word,
  input logic              rsv_seen
);
  localparam int NIB_MSB = WORD_W - 1;

  function automatic logic nib_reserved(input logic [3:0] n);
    nib_reserved = (n == 4'h5) || (n == 4'h3) || (n == 4'h1) || (n == 4'h7);
  endfunction

  // R1 R2: a forwarded control word never carries a reserved code
  assert_fwd_ctl_clean_R1: assert property (@(posedge clk) disable iff (rst)
    (out_we && out_ctl) |-> !nib_reserved(out_word[NIB_MSB -: 4]));

  // R3 R9: every reserved control word yields a pulse on the next cycle
  assert_pulse_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ctl && nib_reserved(in_word[NIB_MSB -: 4])) |=> rsv_seen);

  // R3: a pulse and a write never coincide
  assert_pulse_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    rsv_seen |-> !out_we);

  // R4: the payload word right after a reserved word is not written
  assert_payload_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    (rsv_seen && in_valid && !in_ctl) |=> !out_we);

  // R8: idle input gives no write and no pulse
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_we && !rsv_seen));
endmodule

bind rsv_cw_filter rsv_cw_filter_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/rsv_cw_filter_test.sv
module rsv_cw_filter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ctl;
  logic [15:0] in_word;
  logic        out_we;
  logic        out_ctl;
  logic [15:0] out_word;
  logic        rsv_seen;

  int vectors = 0;
  int miscompares = 0;
  bit model_open;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rsv_cw_filter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctl(in_ctl),
    .in_word(in_word), .out_we(out_we), .out_ctl(out_ctl),
    .out_word(out_word), .rsv_seen(rsv_seen)
  );

  function automatic bit is_rsv(input logic [3:0] n);
    return (n == 4'h5) || (n == 4'h3) || (n == 4'h1) || (n == 4'h7);
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one word at a falling edge, check registered result one clock later
  task automatic apply(input bit v, input bit c, input logic [15:0] w);
    bit e_we, e_pulse;
    string req;
    in_valid = v; in_ctl = c; in_word = w;
    e_pulse = v && c && is_rsv(w[15:12]);
    e_we    = v && ((c && !is_rsv(w[15:12])) || (!c && model_open));
    if (!v) req = "R8";
    else if (e_pulse) req = (w[15:12] == 4'h1 || w[15:12] == 4'h7) ? "R2" : "R1";
    else if (c) req = "R7";
    else req = model_open ? "R5" : "R4";
    if (v && c) model_open = is_rsv(w[15:12]) ? 1'b0 : w[15];
    @(negedge clk);
    check(req, {out_we, rsv_seen, 16'h0}, {e_we, e_pulse, 16'h0});
    if (e_pulse) check("R3", {16'h0, rsv_seen, 1'b0}, {16'h0, 1'b1, 1'b0});
    if (e_we) check("R7", {1'b0, out_ctl, out_word}, {1'b0, c, w});
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_ctl = 1'b0; in_word = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_open = 1'b0;
    check("R6", {out_we, rsv_seen, 16'h0}, 18'h0);
  endtask

  initial begin
    do_reset();
    // R6: payload before any control word is dropped
    apply(1, 0, 16'h1234);
    apply(1, 0, 16'hBEEF);
    // sweep every top nibble with both settings of the lower bits
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < 2; k++) begin
        apply(1, 1, {4'h9, 12'h000});           // open forwarding first
        apply(1, 0, 16'h0F0F ^ 16'(n));
        apply(1, 1, {n[3:0], (k != 0) ? 12'hFFF : 12'h5A0});
        apply(1, 0, 16'hC000 | 16'(n));
        apply(0, 0, 16'hFFFF);                  // R8 idle
        apply(1, 0, 16'h3C3C);
        apply(0, 1, 16'h5000);                  // R8 invalid reserved code
        apply(1, 0, 16'h7777);
      end
    end
    // R9: back-to-back reserved words, then a closing and an opening word (R5)
    apply(1, 1, 16'h8000);
    apply(1, 1, 16'h5001);
    apply(1, 1, 16'h3002);
    apply(1, 1, 16'h1003);
    apply(1, 1, 16'h7004);
    apply(1, 0, 16'hAAAA);
    apply(1, 1, 16'h6000);
    apply(1, 0, 16'hBBBB);
    apply(1, 1, 16'hE000);
    apply(1, 0, 16'hCCCC);
    // R6: reset mid-burst closes forwarding
    do_reset();
    apply(1, 0, 16'hDDDD);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule